// File: doc/BRIEF.md
# Fetch Sequencer with One Branch Delay Slot

This block produces the fetch address for a pipeline in which the instruction after every branch always executes. In the cycle that the decoder flags a branch, the sequencer is already fetching that branch's delay-slot instruction. The decoder supplies the branch target in the same cycle. On the next cycle the sequencer fetches the target speculatively, and it saves the fall-through address (delay-slot address plus one instruction) for later.

The branch outcome is presented in the cycle the target is being fetched. A taken outcome costs nothing, because fetch simply carries on after the target. A not-taken outcome redirects fetch to the saved fall-through address. It also raises a squash flag for one cycle, so that the target instruction, now sitting in decode, becomes a bubble. That bubble is the single lost cycle.

A stall freezes every register. The block does not evaluate branch conditions and has no instruction memory of its own.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next values are `fetch_pc` = RESET_VEC, `fetch_vld` = 0, `squash` = 0, and no branch is pending.
- R2: Fetch is active when `fetch_vld` is 1 and `stall` is 0. In an active cycle with no branch event, the next `fetch_pc` is `fetch_pc` + INSN_BYTES, modulo 2^PC_W.
- R3: An active cycle with no branch pending and `squash` = 0 is a sequential cycle. If `br_dec` is 1 in such a cycle, the current fetch is the delay slot: the next `fetch_pc` is `br_tgt`, and the fall-through address `fetch_pc` + INSN_BYTES is saved.
- R4: The active cycle right after R3 is the speculative cycle. If `br_taken` is 1 there, the next `fetch_pc` is the target + INSN_BYTES and `squash` stays 0.
- R5: If `br_taken` is 0 in the speculative cycle, the next `fetch_pc` is the saved fall-through address and `squash` is 1 for exactly one active cycle.
- R6: `br_dec` has no effect in the speculative cycle (a branch in a delay slot), while `squash` is 1, or while `fetch_vld` is 0.
- R7: `br_taken` has no effect outside the speculative cycle.
- R8: While `stall` is 1, `fetch_pc`, `fetch_vld`, `squash`, the pending branch and the saved fall-through address all hold. A resolution after a stall uses the address saved before it.
- R9: After reset is released, the first non-stalled edge sets `fetch_vld` to 1 without moving `fetch_pc`, so RESET_VEC is presented once with `fetch_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes all sequencer state |
| br_dec | input | 1 | Decode stage holds a branch |
| br_tgt | input | PC_W | Target of the decoded branch |
| br_taken | input | 1 | Branch outcome, sampled in the speculative cycle |
| fetch_pc | output | PC_W | Address being fetched |
| fetch_vld | output | 1 | Fetch address is meaningful |
| squash | output | 1 | Instruction in decode must become a bubble |

## Verification
Two things can arrive together in the speculative cycle: the resolution of the pending branch, and a new branch flag from the delay-slot instruction now in decode. The bench provokes this directly, and random stimulus raises `br_dec` one cycle after another. The result is judged by whether the next address follows the outcome alone and the flag starts no second speculative fetch. A stall landing in the speculative cycle is checked as well: the resolution must be delayed and must still use the saved fall-through address.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic { MODE_SEQ = 1'b0, MODE_SPEC = 1'b1 } fmode_e;
  typedef enum logic [1:0] { NPC_INC = 2'd0, NPC_TGT = 2'd1, NPC_FALL = 2'd2 } npc_sel_e;
endpackage

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            br_dec,
  input  logic            br_taken,
  input  logic [PC_W-1:0] cur_pc,
  output fmode_e          mode_o,
  output logic [PC_W-1:0] fall_o,
  output logic            squash_o,
  output npc_sel_e        sel_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  fmode_e          mode_q, mode_n;
  logic [PC_W-1:0] fall_q, fall_n;
  logic            sq_q, sq_n;

  always_comb begin
    mode_n = mode_q;
    fall_n = fall_q;
    sq_n   = sq_q;
    sel_o  = NPC_INC;
    if (adv) begin
      sq_n = 1'b0;
      if (mode_q == MODE_SPEC) begin
        mode_n = MODE_SEQ;
        if (!br_taken) begin
          sel_o = NPC_FALL;
          sq_n  = 1'b1;
        end
      end else if (br_dec && !sq_q) begin
        mode_n = MODE_SPEC;
        fall_n = cur_pc + STEP;
        sel_o  = NPC_TGT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SEQ;
      fall_q <= '0;
      sq_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      fall_q <= fall_n;
      sq_q   <= sq_n;
    end
  end

  assign mode_o   = mode_q;
  assign fall_o   = fall_q;
  assign squash_o = sq_q;
endmodule

// File: rtl/dfs_npc.sv
module dfs_npc
  import dfs_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  npc_sel_e        sel,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] tgt,
  input  logic [PC_W-1:0] fall,
  output logic [PC_W-1:0] npc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_comb begin
    unique case (sel)
      NPC_TGT:  npc = tgt;
      NPC_FALL: npc = fall;
      default:  npc = cur_pc + STEP;
    endcase
  end
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
  import dfs_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_VEC  = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            br_dec,
  input  logic [PC_W-1:0] br_tgt,
  input  logic            br_taken,
  output logic [PC_W-1:0] fetch_pc,
  output logic            fetch_vld,
  output logic            squash
);
  logic [PC_W-1:0] pc_q, npc, fall_pc;
  logic            vld_q, adv;
  fmode_e          mode;
  npc_sel_e        sel;

  assign adv = vld_q && !stall;

  dfs_ctrl #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .adv(adv), .br_dec(br_dec), .br_taken(br_taken),
    .cur_pc(pc_q), .mode_o(mode), .fall_o(fall_pc), .squash_o(squash), .sel_o(sel)
  );

  dfs_npc #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_npc (
    .sel(sel), .cur_pc(pc_q), .tgt(br_tgt), .fall(fall_pc), .npc(npc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_VEC;
      vld_q <= 1'b0;
    end else begin
      if (!stall) vld_q <= 1'b1;
      if (adv)    pc_q  <= npc;
    end
  end

  assign fetch_pc  = pc_q;
  assign fetch_vld = vld_q;
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk
  import dfs_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_VEC  = 32'h0000_0100
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            br_dec,
  input logic [PC_W-1:0] br_tgt,
  input logic            br_taken,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_vld,
  input logic            squash,
  input fmode_e          mode,
  input logic [PC_W-1:0] fall_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (fetch_pc == RESET_VEC && !fetch_vld && !squash));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !stall && mode == MODE_SEQ && !(br_dec && !squash))
      |=> fetch_pc == $past(fetch_pc) + STEP);

  a_r3_target_next: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !stall && mode == MODE_SEQ && br_dec && !squash)
      |=> (fetch_pc == $past(br_tgt) && mode == MODE_SPEC));

  a_r4_taken_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !stall && mode == MODE_SPEC && br_taken)
      |=> (fetch_pc == $past(fetch_pc) + STEP && !squash));

  a_r5_not_taken_redirect: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !stall && mode == MODE_SPEC && !br_taken)
      |=> (fetch_pc == $past(fall_pc) && squash));

  a_r5_squash_single: assert property (@(posedge clk) disable iff (rst)
    (squash && !stall) |=> !squash);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stall))
      |-> ($stable(fetch_pc) && $stable(squash) && $stable(fetch_vld) && $stable(fall_pc)));
endmodule

bind dslot_fetch_seq dfs_chk #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .br_dec(br_dec), .br_tgt(br_tgt),
  .br_taken(br_taken), .fetch_pc(fetch_pc), .fetch_vld(fetch_vld),
  .squash(squash), .mode(mode), .fall_pc(fall_pc)
);

// File: tb/dslot_fetch_seq_bench.sv
module dslot_fetch_seq_bench;
  localparam int          PC_W = 32;
  localparam logic [31:0] RV   = 32'h0000_0100;
  localparam logic [31:0] STEP = 32'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1, stall = 1'b0, br_dec = 1'b0, br_taken = 1'b0;
  logic [31:0] br_tgt = '0;
  logic [31:0] fetch_pc;
  logic        fetch_vld, squash;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [31:0] m_pc = RV, m_fall = '0;
  logic        m_vld = 1'b0, m_sq = 1'b0, m_pend = 1'b0;
  string       last_tag = "R1";

  always #5 clk = ~clk;

  dslot_fetch_seq #(.PC_W(PC_W), .INSN_BYTES(4), .RESET_VEC(RV)) u_dslot_fetch_seq (
    .clk(clk), .rst(rst), .stall(stall), .br_dec(br_dec), .br_tgt(br_tgt),
    .br_taken(br_taken), .fetch_pc(fetch_pc), .fetch_vld(fetch_vld), .squash(squash)
  );

  function automatic string tag_for(logic r, logic s, logic bd, logic tk);
    if (r)                  return "R1";
    if (s)                  return "R8";
    if (!m_vld)             return bd ? "R9 R6" : "R9";
    if (m_pend)             return tk ? (bd ? "R4 R6" : "R4") : (bd ? "R5 R6" : "R5");
    if (bd && !m_sq)        return "R3";
    if (bd)                 return "R6";
    return tk ? "R2 R7" : "R2";
  endfunction

  task automatic compare();
    checks++;
    if (fetch_pc !== m_pc || fetch_vld !== m_vld || squash !== m_sq) begin
      fails++;
      $display("FAIL %s: pc=%h vld=%b sq=%b expected pc=%h vld=%b sq=%b",
               last_tag, fetch_pc, fetch_vld, squash, m_pc, m_vld, m_sq);
    end
  endtask

  // check outputs, drive inputs for the next edge, advance the reference
  task automatic step(input logic r, input logic s, input logic bd,
                      input logic [31:0] t, input logic tk);
    logic sq_n;
    @(negedge clk);
    compare();
    rst = r; stall = s; br_dec = bd; br_tgt = t; br_taken = tk;
    last_tag = tag_for(r, s, bd, tk);
    if (r) begin
      m_pc = RV; m_vld = 0; m_sq = 0; m_pend = 0; m_fall = '0;
    end else if (!s) begin
      if (!m_vld) m_vld = 1;
      else begin
        sq_n = 0;
        if (m_pend) begin
          m_pend = 0;
          if (tk) m_pc = m_pc + STEP;
          else begin m_pc = m_fall; sq_n = 1; end
        end else if (bd && !m_sq) begin
          m_pend = 1; m_fall = m_pc + STEP; m_pc = t;
        end else m_pc = m_pc + STEP;
        m_sq = sq_n;
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset held
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 32'h40, 1);
    // R9: launch edge, RESET_VEC presented with valid high
    step(0, 0, 1, 32'h80, 0);
    step(0, 0, 0, 0, 1);            // R2 R7: taken ignored in sequential cycle
    step(0, 0, 0, 0, 0);
    // R3/R4: taken branch, zero penalty
    step(0, 0, 1, 32'h2000, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R5 + R6: not taken with a branch flag in the delay slot, then flag while squashing
    step(0, 0, 1, 32'h3000, 0);
    step(0, 0, 1, 32'h5550, 0);
    step(0, 0, 1, 32'h6660, 0);
    step(0, 0, 0, 0, 0);
    // R8: stall in speculative cycle, fall-through kept
    step(0, 0, 1, 32'h7000, 0);
    step(0, 1, 0, 0, 1);
    step(0, 1, 1, 32'h1111_0000, 1);
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);            // stall while squash is high
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R2: wrap at top of address space via a branch target
    step(0, 0, 1, 32'hFFFF_FFF8, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R1: reset in the middle of a pending branch
    step(0, 0, 1, 32'h9000, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);            // stall before launch keeps valid low
    step(0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic s, bd, tk, r;
      r  = ($urandom % 400) == 0;
      s  = ($urandom % 100) < 15;
      bd = ($urandom % 100) < 30;
      tk = $urandom % 2;
      step(r, s, bd, {$urandom} & 32'hFFFF_FFFC, tk);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule